// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits between an interrupt source layer and one processor. It holds the processor's presentation state. A 32-bit accept word packs the current processor priority in bits 31:24 and the number of the pending source in bits 23:0. Beside it sit a hidden pending priority and an inter-processor-interrupt (IPI) priority register.

Priorities are 8-bit values, and a lower number is more favoured. The value 0xFF is the least favoured level, and a source at that level is masked. A source number of zero means that nothing is pending.

The source layer offers interrupts as a source number with a priority. The block decides in the same cycle whether to take the offer or bounce it. A bounce is a one-cycle reject pulse that carries the source number, and the source layer keeps that source for a later resend. A taken offer drives the single interrupt line to the processor.

The processor reaches the block through a small register port. It can set the current priority, set the IPI priority, read and accept the pending interrupt, and write an end-of-interrupt (EOI) word. An EOI is forwarded to the source layer and may also ask the sources to resend. The reserved IPI source number is 2.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the accept word reads 0x00000000, the interrupt line is low, and no reject, EOI or resend pulse is driven; the pending priority and the IPI priority both start at 0xFF.
- R2: An offer whose priority is greater than or equal to the current priority (accept word bits 31:24) gives a reject pulse carrying the offered source in the same cycle, and the accept word does not change.
- R3: An offer is also rejected in the same cycle, with no change of state, when a source is pending whose pending priority is less than or equal to the offered priority.
- R4: An offer that passes both tests is loaded as the pending source and priority, and the interrupt line is high from the next cycle. If another source was pending, that displaced source gets a reject pulse in the same cycle.
- R5: A register write with regOp=1 sets the IPI priority to regWdata[7:0]. If that value is below the current priority, source 2 becomes pending at that priority and the line rises. Any pending source other than 2 is rejected in the same cycle. None of this happens when the existing pending priority is already less than or equal to the new IPI priority.
- R6: A register write with regOp=0 loads the current priority from regWdata[7:0]. When the new value is lower than the old one and a source is pending whose pending priority is not below the new value, the pending source is cleared, the line falls, and the cleared source gets a reject pulse.
- R7: A regOp=0 write whose value is not lower than the old current priority, made while nothing is pending, gives a resend pulse in the same cycle. If the IPI priority is below the new value, source 2 becomes pending at the IPI priority.
- R8: While regOp=2 is presented, rdData holds the whole accept word. After that cycle the line is low, the source field is zero, the current priority equals the old pending priority, and the pending priority is 0xFF.
- R9: A regOp=3 write loads the current priority from regWdata[31:24] and pulses the EOI output with regWdata[23:0] in the same cycle. If nothing is pending, it also pulses resend, and when the IPI priority is below the new current priority it makes source 2 pending at the IPI priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offerValid | input | 1 | An offer from the source layer is present |
| offerSrc | input | 24 | Offered source number |
| offerPrio | input | 8 | Offered priority |
| regValid | input | 1 | A register operation is present |
| regOp | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 EOI |
| regWdata | input | 32 | Write data for the register operation |
| rdData | output | 32 | Current accept word |
| irqOut | output | 1 | Interrupt line to the processor |
| rejectValid | output | 1 | One-cycle reject pulse |
| rejectSrc | output | 24 | Source number being rejected |
| eoiValid | output | 1 | One-cycle EOI pulse to the source layer |
| eoiSrc | output | 24 | Source number being ended |
| resendReq | output | 1 | One-cycle request for the sources to resend |

## Verification
The assertions take for granted that an offer and a register operation never share a cycle. Each cycle yields at most one reject, and the offer would be dropped if both arrived together. One checker property states this input assumption. The random stimulus picks exactly one action per cycle (an offer, one of the four register operations, or idle), so the assumption always holds. Offered source numbers are kept nonzero and away from 2, so the IPI source number only ever appears through the IPI path.

// File: rtl/irq_present_pkg.sv
package irq_present_pkg;
  localparam int SRC_W  = 24;
  localparam int PRIO_W = 8;
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } regOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadPend;
    logic [SRC_W-1:0]  newSrc;
    logic [PRIO_W-1:0] newPrio;
    logic              clearPend;
    logic              ldCppr;
    logic [PRIO_W-1:0] newCppr;
    logic              ldIpi;
    logic [PRIO_W-1:0] newIpi;
  } strobe_t;
endpackage

// File: rtl/irq_present_dp.sv
module irq_present_dp
  import irq_present_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [PRIO_W-1:0] cppr,
  output logic [SRC_W-1:0]  pendSrc,
  output logic [PRIO_W-1:0] pendPrio,
  output logic [PRIO_W-1:0] ipiPrio,
  output logic              irqLine
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cppr     <= '0;
      pendSrc  <= '0;
      pendPrio <= PRIO_LEAST;
      ipiPrio  <= PRIO_LEAST;
      irqLine  <= 1'b0;
    end else begin
      if (strb.ldCppr) cppr <= strb.newCppr;
      if (strb.ldIpi)  ipiPrio <= strb.newIpi;
      if (strb.clearPend) begin
        pendSrc  <= '0;
        pendPrio <= PRIO_LEAST;
        irqLine  <= 1'b0;
      end
      if (strb.loadPend) begin
        pendSrc  <= strb.newSrc;
        pendPrio <= strb.newPrio;
        irqLine  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import irq_present_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic              regValid,
  input  regOp_e            regOp,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [SRC_W-1:0]  pendSrc,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] ipiPrio,
  output strobe_t           strb,
  output logic              rejectValid,
  output logic [SRC_W-1:0]  rejectSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic              pending;
  logic [PRIO_W-1:0] wPrio;
  logic [PRIO_W-1:0] eoiPrio;

  assign pending = (pendSrc != '0);
  assign wPrio   = regWdata[PRIO_W-1:0];
  assign eoiPrio = regWdata[WORD_W-1:SRC_W];

  always_comb begin
    strb        = '0;
    rejectValid = 1'b0;
    rejectSrc   = '0;
    eoiValid    = 1'b0;
    eoiSrc      = '0;
    resendReq   = 1'b0;
    if (regValid) begin
      unique case (regOp)
        OP_SET_CPPR: begin
          strb.ldCppr  = 1'b1;
          strb.newCppr = wPrio;
          if (wPrio < cppr) begin
            if (pending && (wPrio <= pendPrio)) begin
              strb.clearPend = 1'b1;
              rejectValid    = 1'b1;
              rejectSrc      = pendSrc;
            end
          end else if (!pending) begin
            resendReq = 1'b1;
            if (ipiPrio < wPrio) begin
              strb.loadPend = 1'b1;
              strb.newSrc   = IPI_NUM;
              strb.newPrio  = ipiPrio;
            end
          end
        end
        OP_SET_IPI: begin
          strb.ldIpi  = 1'b1;
          strb.newIpi = wPrio;
          if ((wPrio < cppr) && !(pending && (pendPrio <= wPrio))) begin
            strb.loadPend = 1'b1;
            strb.newSrc   = IPI_NUM;
            strb.newPrio  = wPrio;
            if (pending && (pendSrc != IPI_NUM)) begin
              rejectValid = 1'b1;
              rejectSrc   = pendSrc;
            end
          end
        end
        OP_ACCEPT: begin
          strb.clearPend = 1'b1;
          strb.ldCppr    = 1'b1;
          strb.newCppr   = pendPrio;
        end
        OP_EOI: begin
          strb.ldCppr  = 1'b1;
          strb.newCppr = eoiPrio;
          eoiValid     = 1'b1;
          eoiSrc       = regWdata[SRC_W-1:0];
          if (!pending) begin
            resendReq = 1'b1;
            if (ipiPrio < eoiPrio) begin
              strb.loadPend = 1'b1;
              strb.newSrc   = IPI_NUM;
              strb.newPrio  = ipiPrio;
            end
          end
        end
        default: ;
      endcase
    end else if (offerValid) begin
      if ((offerPrio >= cppr) || (pending && (pendPrio <= offerPrio))) begin
        rejectValid = 1'b1;
        rejectSrc   = offerSrc;
      end else begin
        if (pending) begin
          rejectValid = 1'b1;
          rejectSrc   = pendSrc;
        end
        strb.loadPend = 1'b1;
        strb.newSrc   = offerSrc;
        strb.newPrio  = offerPrio;
      end
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
  import irq_present_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic              regValid,
  input  logic [1:0]        regOp,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut,
  output logic              rejectValid,
  output logic [SRC_W-1:0]  rejectSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);
  strobe_t           strb;
  logic [PRIO_W-1:0] cppr;
  logic [SRC_W-1:0]  pendSrc;
  logic [PRIO_W-1:0] pendPrio;
  logic [PRIO_W-1:0] ipiPrio;

  irq_present_ctrl #(.IPI_SRC(IPI_SRC)) u_ctrl (
    .offerValid (offerValid),
    .offerSrc   (offerSrc),
    .offerPrio  (offerPrio),
    .regValid   (regValid),
    .regOp      (regOp_e'(regOp)),
    .regWdata   (regWdata),
    .cppr       (cppr),
    .pendSrc    (pendSrc),
    .pendPrio   (pendPrio),
    .ipiPrio    (ipiPrio),
    .strb       (strb),
    .rejectValid(rejectValid),
    .rejectSrc  (rejectSrc),
    .eoiValid   (eoiValid),
    .eoiSrc     (eoiSrc),
    .resendReq  (resendReq)
  );

  irq_present_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cppr    (cppr),
    .pendSrc (pendSrc),
    .pendPrio(pendPrio),
    .ipiPrio (ipiPrio),
    .irqLine (irqOut)
  );

  assign rdData = {cppr, pendSrc};
endmodule

// File: rtl/irq_present_chk.sv
module irq_present_chk (
  input logic        clk,
  input logic        rstN,
  input logic        offerValid,
  input logic [23:0] offerSrc,
  input logic [7:0]  offerPrio,
  input logic        regValid,
  input logic [1:0]  regOp,
  input logic [31:0] regWdata,
  input logic [31:0] rdData,
  input logic        irqOut,
  input logic        rejectValid,
  input logic [23:0] rejectSrc,
  input logic        eoiValid,
  input logic [23:0] eoiSrc,
  input logic        resendReq
);
  // input assumption: offers and register operations never coincide
  excl_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(offerValid && regValid));

  // R2
  low_offer_rej_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && !regValid && (offerPrio >= rdData[31:24]))
      |-> (rejectValid && (rejectSrc == offerSrc)));

  // R4
  win_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && !regValid && (offerPrio < rdData[31:24]) && (rdData[23:0] == 24'd0))
      |=> (irqOut && (rdData[23:0] == $past(offerSrc))));

  // R4
  line_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (rdData[23:0] != 24'd0));

  // R7
  cppr_resend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && (regOp == 2'd0) && (regWdata[7:0] >= rdData[31:24]) && (rdData[23:0] == 24'd0))
      |-> resendReq);

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && (regOp == 2'd2)) |=> (!irqOut && (rdData[23:0] == 24'd0)));

  // R9
  eoi_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && (regOp == 2'd3)) |-> (eoiValid && (eoiSrc == regWdata[23:0])));

  // R9
  eoi_cppr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && (regOp == 2'd3)) |=> (rdData[31:24] == $past(regWdata[31:24])));

  // R9
  eoi_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && (regOp == 2'd3)) |-> !eoiValid);
endmodule

bind irq_present_unit irq_present_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .offerValid (offerValid),
  .offerSrc   (offerSrc),
  .offerPrio  (offerPrio),
  .regValid   (regValid),
  .regOp      (regOp),
  .regWdata   (regWdata),
  .rdData     (rdData),
  .irqOut     (irqOut),
  .rejectValid(rejectValid),
  .rejectSrc  (rejectSrc),
  .eoiValid   (eoiValid),
  .eoiSrc     (eoiSrc),
  .resendReq  (resendReq)
);

// File: tb/irq_present_unit_bench.sv
`timescale 1ns/100ps
module irq_present_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        offerValid = 1'b0;
  logic [23:0] offerSrc = '0;
  logic [7:0]  offerPrio = '0;
  logic        regValid = 1'b0;
  logic [1:0]  regOp = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic        irqOut, rejectValid, eoiValid, resendReq;
  logic [23:0] rejectSrc, eoiSrc;

  always #2.5 clk = ~clk;

  irq_present_unit u_irq_present_unit (
    .clk(clk), .rstN(rstN), .offerValid(offerValid), .offerSrc(offerSrc),
    .offerPrio(offerPrio), .regValid(regValid), .regOp(regOp), .regWdata(regWdata),
    .rdData(rdData), .irqOut(irqOut), .rejectValid(rejectValid), .rejectSrc(rejectSrc),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendReq(resendReq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0]  mCppr = 8'h00;
  logic [23:0] mSrc  = '0;
  logic [7:0]  mPend = 8'hFF;
  logic [7:0]  mIpi  = 8'hFF;
  logic        mIrq  = 1'b0;
  // expected pulses
  logic        eRej, eEoi, eResend;
  logic [23:0] eRejSrc, eEoiSrc;
  string       lastTag = "R1";

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadPend(input logic [23:0] s, input logic [7:0] p);
    mSrc = s; mPend = p; mIrq = 1'b1;
  endtask

  // expected outcome of one cycle, from the requirements
  task automatic modelEval(input bit ov, input logic [23:0] os, input logic [7:0] op,
                           input bit rv, input logic [1:0] rop, input logic [31:0] wd);
    bit pend;
    pend = (mSrc != 0);
    eRej = 0; eRejSrc = 0; eEoi = 0; eEoiSrc = 0; eResend = 0;
    if (rv) begin
      case (rop)
        2'd0: begin
          if (wd[7:0] < mCppr) begin
            if (pend && wd[7:0] <= mPend) begin
              eRej = 1; eRejSrc = mSrc;
              mSrc = 0; mPend = 8'hFF; mIrq = 0;
            end
          end else if (!pend) begin
            eResend = 1;
            if (mIpi < wd[7:0]) loadPend(24'd2, mIpi);
          end
          mCppr = wd[7:0];
        end
        2'd1: begin
          mIpi = wd[7:0];
          if (wd[7:0] < mCppr && !(pend && mPend <= wd[7:0])) begin
            if (pend && mSrc != 24'd2) begin eRej = 1; eRejSrc = mSrc; end
            loadPend(24'd2, wd[7:0]);
          end
        end
        2'd2: begin
          mCppr = mPend; mSrc = 0; mPend = 8'hFF; mIrq = 0;
        end
        default: begin
          mCppr = wd[31:24];
          eEoi = 1; eEoiSrc = wd[23:0];
          if (!pend) begin
            eResend = 1;
            if (mIpi < mCppr) loadPend(24'd2, mIpi);
          end
        end
      endcase
    end else if (ov) begin
      if (op >= mCppr || (pend && mPend <= op)) begin
        eRej = 1; eRejSrc = os;
      end else begin
        if (pend) begin eRej = 1; eRejSrc = mSrc; end
        loadPend(os, op);
      end
    end
  endtask

  task automatic checkState();
    check(rdData == {mCppr, mSrc}, lastTag, rdData, {mCppr, mSrc});
    check(irqOut == mIrq, lastTag, 32'(irqOut), 32'(mIrq));
  endtask

  task automatic step(input string tag, input bit ov, input logic [23:0] os,
                      input logic [7:0] op, input bit rv, input logic [1:0] rop,
                      input logic [31:0] wd);
    @(negedge clk);
    checkState();
    offerValid = ov; offerSrc = os; offerPrio = op;
    regValid = rv; regOp = rop; regWdata = wd;
    #1;
    modelEval(ov, os, op, rv, rop, wd);
    check(rejectValid == eRej, tag, 32'(rejectValid), 32'(eRej));
    if (eRej) check(rejectSrc == eRejSrc, tag, 32'(rejectSrc), 32'(eRejSrc));
    check(eoiValid == eEoi, tag, 32'(eoiValid), 32'(eEoi));
    if (eEoi) check(eoiSrc == eEoiSrc, tag, 32'(eoiSrc), 32'(eEoiSrc));
    check(resendReq == eResend, tag, 32'(resendReq), 32'(eResend));
    lastTag = tag;
  endtask

  task automatic offer(input string tag, input logic [23:0] s, input logic [7:0] p);
    step(tag, 1'b1, s, p, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic regop(input string tag, input logic [1:0] o, input logic [31:0] w);
    step(tag, 1'b0, 24'd0, 8'd0, 1'b1, o, w);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 24'd0, 8'd0, 1'b0, 2'd0, 32'd0);
  endtask

  function automatic logic [7:0] pickPrio();
    return ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 8);
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    idle("R1");
    // R2 current priority 0 rejects everything
    offer("R2", 24'd5, 8'd3);
    // R7 opening priority to FF with nothing pending -> resend
    regop("R7", 2'd0, 32'h0000_00FF);
    // R4 accepted offer
    offer("R4", 24'd5, 8'd4);
    // R3 equal pending priority rejects
    offer("R3", 24'd6, 8'd4);
    // R4 better offer displaces source 5
    offer("R4", 24'd7, 8'd2);
    // R5 IPI not better than pending: no effect
    regop("R5", 2'd1, 32'h0000_0003);
    // R5 IPI better: rejects 7, presents source 2
    regop("R5", 2'd1, 32'h0000_0001);
    // R8 accept
    regop("R8", 2'd2, 32'd0);
    // R9 EOI, nothing pending, IPI re-presented
    regop("R9", 2'd3, 32'hFF00_0002);
    // R6 lower priority clears pending IPI
    regop("R6", 2'd0, 32'h0000_0001);
    regop("R5", 2'd1, 32'h0000_00FF);
    regop("R7", 2'd0, 32'h0000_00FF);
    offer("R4", 24'd9, 8'd0);
    regop("R6", 2'd0, 32'h0000_0000);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom % 10;
      if (k < 4)       offer("R4", 24'(3 + $urandom % 13), pickPrio());
      else if (k == 4) regop("R6", 2'd0, 32'(pickPrio()));
      else if (k == 5) regop("R5", 2'd1, 32'(pickPrio()));
      else if (k == 6) regop("R8", 2'd2, 32'd0);
      else if (k == 7) regop("R9", 2'd3, {pickPrio(), 24'(3 + $urandom % 13)});
      else             idle("R2");
    end
    idle("R3");
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule